// File: doc/BRIEF.md
# Watchdog Timer with Tick Prescaler

This block is a bus-mapped watchdog for a system chip. A prescaler divides the input clock into a slow tick, nominally one millisecond. A 16-bit elapsed counter advances on each tick while the watchdog runs. When the elapsed count reaches a limit set by software, the block enters an expired state and, if reset generation is allowed, raises a reset request that the system reset controller acts on. Software must keep writing a restart word to hold the request off.

There are three words on a simple word-addressed port. The control word holds the divide value and four enable bits. The limit word holds the programmed limit, and on read it also returns the live elapsed count. A write of any value to the restart word clears the count. Reads are combinational from the addressed word. Writes take effect at the clock edge on which `bus_wr` is sampled high.

A three-state machine drives the sequencing:
- STOPPED is entered from reset and from any state when the run bit is cleared.
- STOPPED goes to COUNTING (the "arm" transition) when the run bit is set.
- COUNTING goes to EXPIRED (the "expire" transition) when the elapsed count is at or above the limit.
- EXPIRED goes back to COUNTING (the "restart" transition) on a restart write.
- COUNTING and EXPIRED go to STOPPED (the "disarm" transition) when the run bit is clear.

Top module: `wdt_core`

## Requirements
- R1: After reset, the control, limit and restart words all read 0, and `rst_req` is low.
- R2: The control word at byte offset 0x0 keeps only these bits: [17:0] divide value, 18 run, 21 reset-generation enable, 24 tick-clock enable, 25 divider enable. All other bits read 0 and ignore writes.
- R3: The limit word at offset 0x8 stores bits [15:0] of a write and ignores bits [31:16]. A read returns the limit in [15:0] and the elapsed count in [31:16].
- R4: When bits 24 and 25 are both set and the divide value is D, a tick occurs once every D+1 clocks; D = 0 gives a tick on every clock. When either bit is clear, no ticks occur and the count does not move.
- R5: The elapsed count rises by exactly one per tick only while the run bit is set and the state is not EXPIRED. It never passes the limit and holds once it reaches it.
- R6: While running, an elapsed count at or above the limit moves the block to EXPIRED on the next edge. `rst_req` is high exactly while the block is EXPIRED and bit 21 is set.
- R7: A write of any data to offset 0xC clears the elapsed count to 0 and leaves EXPIRED on the next edge.
- R8: Clearing the run bit leaves EXPIRED and drops `rst_req`, while the elapsed count is kept. Setting the bit again resumes counting from the kept value.
- R9: Offset 0x4 and the restart word at 0xC read 0, and a write to 0x4 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the prescaler input |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 4 | Byte address; bits [3:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| rst_req | output | 1 | Reset request, high while expired with reset generation on |

## Verification
The bench goes after these corner cases:
- **Divide value 0.** A prescaler that waits one extra clock would count at half speed, and the live count would fall behind.
- **Limit 0, or a limit written below the current count.** A design that compares only for equality would run past the limit and never raise the request.
- **Restart while expired.** A design that clears the count but not the state would keep `rst_req` high.
- **Disarm while expired.** A design that clears the count on disarm would lose progress, and one that keeps the expired state would hold the request with the watchdog off.
- **Writes to the ignored bits and to the unused word.** A wrong write mask would corrupt the divide value or the limit.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    // Control word layout; software depends on these positions.
    localparam int DIV_W       = 18;
    localparam int BIT_RUN     = 18;
    localparam int BIT_RSTGEN  = 21;
    localparam int BIT_CLKEN   = 24;
    localparam int BIT_DIVEN   = 25;

    localparam logic [31:0] CTRL_MASK =
        (32'd1 << BIT_DIVEN) | (32'd1 << BIT_CLKEN) |
        (32'd1 << BIT_RSTGEN) | (32'd1 << BIT_RUN) |
        ((32'd1 << DIV_W) - 32'd1);

    // Word indices taken from byte address bits [3:2].
    localparam logic [1:0] W_CTRL  = 2'd0;
    localparam logic [1:0] W_LIMIT = 2'd2;
    localparam logic [1:0] W_KICK  = 2'd3;

    typedef enum logic [1:0] {
        ST_STOPPED  = 2'd0,
        ST_COUNTING = 2'd1,
        ST_EXPIRED  = 2'd2
    } wdt_state_e;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  elapsed,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [CNT_W-1:0]  limit_q,
    output logic              kick,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [DATA_W-1:0] MASK_W = DATA_W'(CTRL_MASK);

    logic [1:0] word;
    assign word = addr[3:2];
    assign kick = wr_en && (word == W_KICK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            limit_q <= '0;
        end else if (wr_en) begin
            if (word == W_CTRL)  ctrl_q  <= wdata & MASK_W;
            if (word == W_LIMIT) limit_q <= wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (word == W_CTRL)       rdata = ctrl_q;
        else if (word == W_LIMIT) rdata[2*CNT_W-1:0] = {elapsed, limit_q};
    end
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] pcnt_q;

    assign tick = run && (pcnt_q >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            pcnt_q <= '0;
        else if (!run || tick) pcnt_q <= '0;
        else                   pcnt_q <= pcnt_q + 1'b1;
    end
endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             kick,
    input  logic             tick,
    input  logic             rst_gen,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] elapsed,
    output logic             expired,
    output logic             rst_req
);
    wdt_state_e state_q, state_d;
    logic       advance;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED:  if (enable) state_d = ST_COUNTING;
            ST_COUNTING: begin
                if (!enable)                state_d = ST_STOPPED;
                else if (kick)              state_d = ST_COUNTING;
                else if (elapsed >= limit)  state_d = ST_EXPIRED;
            end
            ST_EXPIRED: begin
                if (!enable)    state_d = ST_STOPPED;
                else if (kick)  state_d = ST_COUNTING;
            end
            default: state_d = ST_STOPPED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    assign advance = enable && tick && (state_q != ST_EXPIRED) && (elapsed < limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       elapsed <= '0;
        else if (kick)    elapsed <= '0;
        else if (advance) elapsed <= elapsed + 1'b1;
    end

    always_comb begin
        expired = (state_q == ST_EXPIRED);
        rst_req = expired && rst_gen;
    end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req
);
    logic [DATA_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  limit_q;
    logic [CNT_W-1:0]  elapsed_q;
    logic              kick;
    logic              tick;
    logic              expired;

    wdt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .elapsed (elapsed_q),
        .ctrl_q  (ctrl_q),
        .limit_q (limit_q),
        .kick    (kick),
        .rdata   (bus_rdata)
    );

    wdt_prescale u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl_q[BIT_CLKEN] & ctrl_q[BIT_DIVEN]),
        .div   (ctrl_q[DIV_W-1:0]),
        .tick  (tick)
    );

    wdt_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (ctrl_q[BIT_RUN]),
        .kick    (kick),
        .tick    (tick),
        .rst_gen (ctrl_q[BIT_RSTGEN]),
        .limit   (limit_q),
        .elapsed (elapsed_q),
        .expired (expired),
        .rst_req (rst_req)
    );
endmodule

// File: rtl/wdt_core_chk.sv
module wdt_core_chk
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] ctrl,
    input logic [CNT_W-1:0]  limit,
    input logic [CNT_W-1:0]  elapsed,
    input logic              kick,
    input logic              expired,
    input logic              rst_req
);
    p_gate_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ctrl[BIT_CLKEN] && ctrl[BIT_DIVEN]) && !kick) |=> $stable(elapsed));

    p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(kick) |-> (elapsed == $past(elapsed)) || (elapsed == $past(elapsed) + 1'b1));

    p_hold_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(elapsed) >= $past(limit) && !$past(kick)) |-> elapsed == $past(elapsed));

    p_expire_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(elapsed) >= $past(limit));

    p_req_only_expired_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> expired);

    p_restart_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (elapsed == '0) && !expired);

    p_disarm_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[BIT_RUN] |=> !expired && !rst_req);
endmodule

bind wdt_core wdt_core_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl_q),
    .limit   (limit_q),
    .elapsed (elapsed_q),
    .kick    (kick),
    .expired (expired),
    .rst_req (rst_req)
);

// File: tb/sim_wdt_core.sv
module sim_wdt_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        rst_req;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_tag = "R1";

    // Reference state, from the requirements
    logic [31:0] m_ctrl;
    logic [15:0] m_lim, m_el;
    logic [17:0] m_pc;
    int          m_st;   // 0 stopped, 1 counting, 2 expired

    always #10 clk = ~clk;

    wdt_core u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .rst_req(rst_req)
    );

    always @(posedge clk) begin : mdl
        logic g, tk, kk;
        int nst;
        if (!rst_n) begin
            m_ctrl = '0; m_lim = '0; m_el = '0; m_pc = '0; m_st = 0;
        end else begin
            g  = m_ctrl[24] & m_ctrl[25];
            tk = g && (m_pc >= m_ctrl[17:0]);           // R4
            kk = wr && (addr[3:2] == 2'd3);              // R7
            if (!m_ctrl[18])                       nst = 0;   // R8
            else if (m_st == 0)                    nst = 1;
            else if (kk)                           nst = 1;
            else if (m_st == 1 && m_el >= m_lim)   nst = 2;   // R6
            else                                   nst = m_st;
            if (kk) m_el = '0;
            else if (m_ctrl[18] && m_st != 2 && tk && m_el < m_lim) m_el = m_el + 16'd1; // R5
            m_pc = (!g || tk) ? 18'd0 : m_pc + 18'd1;
            m_st = nst;
            if (wr && addr[3:2] == 2'd0) m_ctrl = wdata & 32'h0327_FFFF;   // R2
            if (wr && addr[3:2] == 2'd2) m_lim  = wdata[15:0];            // R3
        end
    end

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        case (a[3:2])
            2'd0:    return m_ctrl;
            2'd2:    return {m_el, m_lim};
            default: return 32'd0;                        // R9
        endcase
    endfunction

    task automatic step(input logic w, input logic [3:0] a, input logic [31:0] d);
        logic [31:0] e;
        logic        er;
        @(negedge clk);
        e  = exp_rd(addr);
        er = (m_st == 2) && m_ctrl[21];
        n_chk++;
        if (rdata !== e) begin
            n_bad++;
            $display("FAIL %s rdata addr=%h actual=%h expected=%h", cur_tag, addr, rdata, e);
        end
        n_chk++;
        if (rst_req !== er) begin
            n_bad++;
            $display("FAIL %s R6 rst_req actual=%b expected=%b", cur_tag, rst_req, er);
        end
        wr = w; addr = a; wdata = d;
    endtask

    task automatic idle(input int n, input logic [3:0] a);
        for (int i = 0; i < n; i++) step(1'b0, a, 32'd0);
    endtask

    localparam logic [31:0] CE = 32'h0100_0000, DE = 32'h0200_0000,
                            GEN = 32'h0020_0000, RUN = 32'h0004_0000;

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cur_tag = "R1";
        step(0, 4'h0, 0); step(0, 4'h8, 0); step(0, 4'hC, 0); step(0, 4'h0, 0);
        // R2 masked control bits
        cur_tag = "R2";
        step(1, 4'h0, 32'hFFFF_FFFF); idle(3, 4'h0);
        step(1, 4'h0, 32'h0); idle(2, 4'h0);
        // R3 limit upper bits ignored
        cur_tag = "R3";
        step(1, 4'h8, 32'hFFFF_1234); step(1, 4'hC, 32'h0); idle(3, 4'h8);
        // R4 prescaler, divide 2 then divide 0, then gated off
        cur_tag = "R4";
        step(1, 4'h8, 32'd50); step(1, 4'h0, CE | DE | RUN | 32'd2); idle(12, 4'h8);
        step(1, 4'h0, CE | DE | RUN | 32'd0); idle(8, 4'h8);
        step(1, 4'h0, DE | RUN); idle(6, 4'h8);
        // R5 R6 expiry with limit 5, divide 0
        cur_tag = "R5 R6";
        step(1, 4'h8, 32'd5); step(1, 4'hC, 32'd0);
        step(1, 4'h0, CE | DE | RUN | GEN); idle(12, 4'h8);
        // R7 restart out of expired with arbitrary data
        cur_tag = "R7";
        step(1, 4'hC, 32'hDEAD_BEEF); idle(3, 4'h8); idle(8, 4'h8);
        // R8 disarm while expired, then resume
        cur_tag = "R8";
        step(1, 4'h0, CE | DE | GEN); idle(4, 4'h8);
        step(1, 4'h8, 32'd9); step(1, 4'h0, CE | DE | RUN | GEN | 32'd1); idle(14, 4'h8);
        // R6 limit written below current count
        cur_tag = "R6";
        step(1, 4'h8, 32'd2); idle(4, 4'h8);
        step(1, 4'h0, CE | DE | RUN | 32'd1); idle(3, 4'h8);
        // R9 unused word
        cur_tag = "R9";
        step(1, 4'h4, 32'hFFFF_FFFF); idle(2, 4'h4); idle(2, 4'hC); idle(2, 4'h0); idle(2, 4'h8);
        // Random mix
        cur_tag = "R2 R3 R4 R5 R6 R7 R8 R9 random";
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom % 100;
            if (r < 3)
                step(1, 4'h0, ($urandom & 32'hFCD8_0000) |
                     (($urandom % 8 != 0) ? RUN : 32'd0) |
                     (($urandom % 6 != 0) ? CE : 32'd0) |
                     (($urandom % 6 != 0) ? DE : 32'd0) |
                     (($urandom % 2 != 0) ? GEN : 32'd0) | ($urandom % 4));
            else if (r < 6)  step(1, 4'h8, ($urandom & 32'hFFFF_0000) | ($urandom % 24));
            else if (r < 9)  step(1, 4'hC, $urandom);
            else if (r < 11) step(1, 4'h4, $urandom);
            else             step(0, 4'({2'($urandom % 4), 2'b00}), 32'd0);
        end
        step(0, 4'h8, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule